// File: doc/BRIEF.md
# Stereo Audio Transmit Buffer Controller

This block sits between a processor-side write port and a serial audio shifter. It holds up to four stereo sample pairs, each a left and a right sample, and presents the oldest pair to the shifter. The shifter takes a pair with a read strobe. The processor adds pairs with a write strobe. Each sample is 24 bits wide, or 16 bits when narrow mode is selected.

A monitored state machine controls the buffer and reports its condition as a 3-bit code. A start request first clears all four slots, one per clock, and then opens the buffer for traffic. While it runs, the code shows whether the buffer is empty, partly filled or full. A stop request does not discard pairs that are still queued. The machine drains them to the shifter and returns to idle only once the buffer is empty. Full and empty flags are provided next to the code, together with one-cycle pulses that report a write that was dropped and a read that found nothing.

Top module: `stx_fifo_ctrl`

## Requirements
- R1: The state codes are 0 idle, 1 priming, 2 full, 3 partly filled, 4 empty and 5 draining. Codes 6 and 7 never appear. While reset is low, and after it is released, `state_o` is 0, `empty_o` is 1, `full_o` is 0, both head outputs are zero and both pulse outputs are 0.
- R2: When `start_i` is high in the idle state, the state becomes priming (1) at the next edge. Priming lasts exactly four cycles and clears one slot per cycle. The state then becomes empty (4).
- R3: In the empty, partly filled and full states, a write that is not blocked stores one pair. The code then follows the number of stored pairs: 0 gives empty (4), 1 to 3 give partly filled (3), and 4 gives full (2). `full_o` is 1 exactly when four pairs are stored, and `empty_o` is 1 exactly when none are stored.
- R4: A write while four pairs are stored is dropped, and the stored contents do not change. In the empty, partly filled and full states this raises `overflow_o` for the one following cycle.
- R5: The head outputs show the oldest stored pair. Reads remove pairs in the order they were written, and a read from a full buffer clears `full_o`.
- R6: While no pair is stored, both head outputs are zero. A read in the empty state removes nothing and raises `underrun_o` for the one following cycle.
- R7: A stop request in the empty, partly filled or full state enters draining (5) if any pair remains after that cycle's read. In the stop cycle and while draining, writes are ignored and raise no pulse. Reads keep removing pairs. The state returns to idle (0) at the edge that removes the last pair.
- R8: A stop request in those states goes directly to idle (0) when no pair remains after that cycle's read. A stop request in the idle state has no effect.
- R9: When `wide_i` is 0 at a write, only bits 15:0 of each written sample are stored, and bits 23:16 read back as zero. When `wide_i` is 1, all 24 bits are stored.
- R10: In the idle and priming states, writes and reads are ignored. The buffer stays empty and neither pulse is raised.
- R11: A simultaneous read and write in the partly filled state keeps the count unchanged. In the full state the read removes a pair, the write is dropped with an overflow pulse, and the state becomes partly filled (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to prime and open the buffer |
| stop_i | input | 1 | Request to drain and return to idle |
| wide_i | input | 1 | Sample width at write: 1 for 24-bit, 0 for 16-bit |
| wr_i | input | 1 | Write strobe for one stereo pair |
| wr_left_i | input | 24 | Left sample to write |
| wr_right_i | input | 24 | Right sample to write |
| rd_i | input | 1 | Read strobe from the serial shifter |
| head_left_o | output | 24 | Left sample of the oldest pair, zero when empty |
| head_right_o | output | 24 | Right sample of the oldest pair, zero when empty |
| state_o | output | 3 | Buffer state code |
| full_o | output | 1 | Four pairs stored |
| empty_o | output | 1 | No pair stored |
| overflow_o | output | 1 | One-cycle pulse after a dropped write |
| underrun_o | output | 1 | One-cycle pulse after a read on an empty buffer |

## Verification
The assertions check on every cycle the rules that hold locally. These are: the legal code range, flags that are never both set, no store while full or while draining, the entry into priming and its four-cycle bound, zero heads while empty, the pulse after a blocked write or an empty read, and the return to idle on the last drained pair. Some behaviour only the bench scenarios can show, because it depends on the data. This covers first-in first-out order across pointer wrap-around, the masking of narrow samples, the count produced by combined reads and writes, and the different outcomes of a stop request at different fill levels.

// File: rtl/stx_fifo_pkg.sv
package stx_fifo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRIME = 3'd1,
    ST_BRIM  = 3'd2,
    ST_PART  = 3'd3,
    ST_DRY   = 3'd4,
    ST_DRAIN = 3'd5
  } txf_state_e;

  // state that the running buffer shows for a given fill count
  function automatic txf_state_e level_state(input int unsigned lvl, input int unsigned depth);
    if (lvl == 0)
      return ST_DRY;
    else if (lvl >= depth)
      return ST_BRIM;
    else
      return ST_PART;
  endfunction

  function automatic logic is_running(input txf_state_e s);
    return (s == ST_DRY) || (s == ST_PART) || (s == ST_BRIM);
  endfunction

endpackage

// File: rtl/stx_fifo_fsm.sv
module stx_fifo_fsm
  import stx_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [LVL_W-1:0] level_i,
  output txf_state_e       state_o,
  output logic             push_o,
  output logic             pop_o,
  output logic             clr_o,
  output logic [IDX_W-1:0] clr_idx_o,
  output logic             rewind_o,
  output logic             ovf_evt_o,
  output logic             unf_evt_o
);

  txf_state_e       state_q, state_nx;
  logic [IDX_W-1:0] prime_q, prime_nx;
  logic [LVL_W-1:0] level_nx;
  logic             running, is_full, is_empty;

  always_comb begin
    running   = is_running(state_q);
    is_full   = (level_i == LVL_W'(DEPTH));
    is_empty  = (level_i == '0);
    pop_o     = (running || state_q == ST_DRAIN) && rd_i && !is_empty;
    push_o    = running && !stop_i && wr_i && !is_full;
    ovf_evt_o = running && !stop_i && wr_i && is_full;
    unf_evt_o = running && rd_i && is_empty;
    clr_o     = (state_q == ST_PRIME);
    clr_idx_o = prime_q;
    rewind_o  = (state_q == ST_IDLE) && start_i;
    level_nx  = level_i + LVL_W'(push_o) - LVL_W'(pop_o);

    state_nx = state_q;
    prime_nx = prime_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_nx = ST_PRIME;
          prime_nx = '0;
        end
      end
      ST_PRIME: begin
        prime_nx = prime_q + IDX_W'(1);
        if (prime_q == IDX_W'(DEPTH - 1))
          state_nx = ST_DRY;
      end
      ST_DRY, ST_PART, ST_BRIM: begin
        if (stop_i)
          state_nx = (level_nx != '0) ? ST_DRAIN : ST_IDLE;
        else
          state_nx = level_state(32'(level_nx), 32'(DEPTH));
      end
      ST_DRAIN: begin
        if (level_nx == '0)
          state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prime_q <= '0;
    end else begin
      state_q <= state_nx;
      prime_q <= prime_nx;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/stx_fifo_store.sv
module stx_fifo_store #(
  parameter int DEPTH    = 4,
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic                pop_i,
  input  logic                clr_i,
  input  logic [IDX_W-1:0]    clr_idx_i,
  input  logic                rewind_i,
  input  logic                wide_i,
  input  logic [SAMPLE_W-1:0] wr_left_i,
  input  logic [SAMPLE_W-1:0] wr_right_i,
  output logic [LVL_W-1:0]    level_o,
  output logic [SAMPLE_W-1:0] head_left_o,
  output logic [SAMPLE_W-1:0] head_right_o
);

  localparam logic [SAMPLE_W-1:0] LOW_MASK = {SAMPLE_W{1'b1}} >> (SAMPLE_W - NARROW_W);

  function automatic logic [SAMPLE_W-1:0] fit_sample(input logic [SAMPLE_W-1:0] s, input logic wide);
    return wide ? s : (s & LOW_MASK);
  endfunction

  function automatic logic [IDX_W-1:0] step_ptr(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  logic [DEPTH*SAMPLE_W-1:0] flat_l, flat_r;
  logic [IDX_W-1:0]          wp_q, rp_q;
  logic [LVL_W-1:0]          level_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [SAMPLE_W-1:0] l_q, r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        l_q <= '0;
        r_q <= '0;
      end else if (clr_i && clr_idx_i == IDX_W'(g)) begin
        l_q <= '0;
        r_q <= '0;
      end else if (push_i && wp_q == IDX_W'(g)) begin
        l_q <= fit_sample(wr_left_i, wide_i);
        r_q <= fit_sample(wr_right_i, wide_i);
      end
    end
    assign flat_l[g*SAMPLE_W +: SAMPLE_W] = l_q;
    assign flat_r[g*SAMPLE_W +: SAMPLE_W] = r_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
    end else if (rewind_i) begin
      wp_q    <= '0;
      rp_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_i) wp_q <= step_ptr(wp_q);
      if (pop_i)  rp_q <= step_ptr(rp_q);
      level_q <= level_q + LVL_W'(push_i) - LVL_W'(pop_i);
    end
  end

  assign level_o      = level_q;
  assign head_left_o  = (level_q == '0) ? '0 : flat_l[32'(rp_q)*SAMPLE_W +: SAMPLE_W];
  assign head_right_o = (level_q == '0) ? '0 : flat_r[32'(rp_q)*SAMPLE_W +: SAMPLE_W];

endmodule

// File: rtl/stx_fifo_evt.sv
module stx_fifo_evt #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] pulse_o
);

  for (genvar g = 0; g < N; g++) begin : g_pulse
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_o[g] <= 1'b0;
      else        pulse_o[g] <= evt_i[g];
    end
  end

endmodule

// File: rtl/stx_fifo_ctrl.sv
module stx_fifo_ctrl
  import stx_fifo_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int SAMPLE_W = 24,
  parameter int NARROW_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                stop_i,
  input  logic                wide_i,
  input  logic                wr_i,
  input  logic [SAMPLE_W-1:0] wr_left_i,
  input  logic [SAMPLE_W-1:0] wr_right_i,
  input  logic                rd_i,
  output logic [SAMPLE_W-1:0] head_left_o,
  output logic [SAMPLE_W-1:0] head_right_o,
  output logic [2:0]          state_o,
  output logic                full_o,
  output logic                empty_o,
  output logic                overflow_o,
  output logic                underrun_o
);

  txf_state_e       state_w;
  logic             push_w, pop_w, clr_w, rewind_w, ovf_evt_w, unf_evt_w;
  logic [IDX_W-1:0] clr_idx_w;
  logic [LVL_W-1:0] level_w;

  stx_fifo_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .level_i   (level_w),
    .state_o   (state_w),
    .push_o    (push_w),
    .pop_o     (pop_w),
    .clr_o     (clr_w),
    .clr_idx_o (clr_idx_w),
    .rewind_o  (rewind_w),
    .ovf_evt_o (ovf_evt_w),
    .unf_evt_o (unf_evt_w)
  );

  stx_fifo_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_w),
    .pop_i        (pop_w),
    .clr_i        (clr_w),
    .clr_idx_i    (clr_idx_w),
    .rewind_i     (rewind_w),
    .wide_i       (wide_i),
    .wr_left_i    (wr_left_i),
    .wr_right_i   (wr_right_i),
    .level_o      (level_w),
    .head_left_o  (head_left_o),
    .head_right_o (head_right_o)
  );

  stx_fifo_evt #(.N(2)) u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   ({ovf_evt_w, unf_evt_w}),
    .pulse_o ({overflow_o, underrun_o})
  );

  assign state_o = state_w;
  assign full_o  = (level_w == LVL_W'(DEPTH));
  assign empty_o = (level_w == '0);

endmodule

// File: rtl/stx_fifo_chk.sv
module stx_fifo_chk
  import stx_fifo_pkg::*;
#(
  parameter int DEPTH    = 4,
  parameter int SAMPLE_W = 24,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                stop_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [2:0]          state_o,
  input logic                full_o,
  input logic                empty_o,
  input logic                overflow_o,
  input logic                underrun_o,
  input logic [SAMPLE_W-1:0] head_left_o,
  input logic [SAMPLE_W-1:0] head_right_o,
  input logic                push_w,
  input logic                pop_w,
  input logic [LVL_W-1:0]    level_w
);

  logic       run_s;
  logic [7:0] prime_run;

  assign run_s = (state_o == ST_DRY) || (state_o == ST_PART) || (state_o == ST_BRIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  prime_run <= '0;
    else if (state_o == ST_PRIME) prime_run <= prime_run + 8'd1;
    else                         prime_run <= '0;
  end

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd5);

  p_prime_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE && start_i) |=> (state_o == ST_PRIME));

  p_prime_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_PRIME) |-> (prime_run < 8'(DEPTH)));

  p_flags_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !push_w);

  p_ovf_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_s && full_o && wr_i && !stop_i) |=> overflow_o);

  p_empty_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (head_left_o == '0 && head_right_o == '0));

  p_unf_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_DRY && rd_i) |=> underrun_o);

  p_drain_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_DRAIN) |-> !push_w);

  p_drain_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_DRAIN && pop_w && level_w == LVL_W'(1)) |=> (state_o == ST_IDLE));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_IDLE || state_o == ST_PRIME) |-> (empty_o && !push_w && !pop_w));

  p_both_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w && pop_w) |=> $stable(level_w));

endmodule

bind stx_fifo_ctrl stx_fifo_chk #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .wr_i         (wr_i),
  .rd_i         (rd_i),
  .state_o      (state_o),
  .full_o       (full_o),
  .empty_o      (empty_o),
  .overflow_o   (overflow_o),
  .underrun_o   (underrun_o),
  .head_left_o  (head_left_o),
  .head_right_o (head_right_o),
  .push_w       (push_w),
  .pop_w        (pop_w),
  .level_w      (level_w)
);

// File: tb/stx_fifo_ctrl_test.sv
`timescale 1ns/1ps
module stx_fifo_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, stop_i = 1'b0, wide_i = 1'b1, wr_i = 1'b0, rd_i = 1'b0;
  logic [23:0] wr_left_i = '0, wr_right_i = '0;
  logic [23:0] head_left_o, head_right_o;
  logic [2:0]  state_o;
  logic        full_o, empty_o, overflow_o, underrun_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  stx_fifo_ctrl uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .wide_i(wide_i),
    .wr_i(wr_i), .wr_left_i(wr_left_i), .wr_right_i(wr_right_i), .rd_i(rd_i),
    .head_left_o(head_left_o), .head_right_o(head_right_o), .state_o(state_o),
    .full_o(full_o), .empty_o(empty_o), .overflow_o(overflow_o), .underrun_o(underrun_o)
  );

  // ctl = {start, stop, wide, wr, rd}; flg = {full, empty, overflow, underrun}
  typedef struct packed {
    logic [3:0]  req;
    logic [4:0]  ctl;
    logic [23:0] l, r;
    logic [2:0]  st;
    logic [3:0]  flg;
    logic [23:0] hl, hr;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t TBL [NV] = '{
    '{4'd10, 5'b00100, 24'h0,      24'h0,      3'd0, 4'b0100, 24'h0,      24'h0},      // R10 idle
    '{4'd10, 5'b00110, 24'h111111, 24'h222222, 3'd0, 4'b0100, 24'h0,      24'h0},      // R10 write in idle
    '{4'd10, 5'b00101, 24'h0,      24'h0,      3'd0, 4'b0100, 24'h0,      24'h0},      // R10 read in idle
    '{4'd2,  5'b10100, 24'h0,      24'h0,      3'd1, 4'b0100, 24'h0,      24'h0},      // R2 start
    '{4'd2,  5'b00100, 24'h0,      24'h0,      3'd1, 4'b0100, 24'h0,      24'h0},      // R2
    '{4'd10, 5'b00110, 24'h111111, 24'h222222, 3'd1, 4'b0100, 24'h0,      24'h0},      // R10 write in prime
    '{4'd2,  5'b00100, 24'h0,      24'h0,      3'd1, 4'b0100, 24'h0,      24'h0},      // R2
    '{4'd2,  5'b00100, 24'h0,      24'h0,      3'd4, 4'b0100, 24'h0,      24'h0},      // R2 to empty
    '{4'd6,  5'b00101, 24'h0,      24'h0,      3'd4, 4'b0101, 24'h0,      24'h0},      // R6 underrun
    '{4'd6,  5'b00100, 24'h0,      24'h0,      3'd4, 4'b0100, 24'h0,      24'h0},      // R6 pulse ends
    '{4'd3,  5'b00110, 24'h111111, 24'h222222, 3'd3, 4'b0000, 24'h111111, 24'h222222}, // R3
    '{4'd3,  5'b00110, 24'h333333, 24'h444444, 3'd3, 4'b0000, 24'h111111, 24'h222222}, // R3
    '{4'd3,  5'b00110, 24'h555555, 24'h666666, 3'd3, 4'b0000, 24'h111111, 24'h222222}, // R3
    '{4'd3,  5'b00110, 24'h777777, 24'h888888, 3'd2, 4'b1000, 24'h111111, 24'h222222}, // R3 full
    '{4'd4,  5'b00110, 24'h999999, 24'hAAAAAA, 3'd2, 4'b1010, 24'h111111, 24'h222222}, // R4 overflow
    '{4'd4,  5'b00100, 24'h0,      24'h0,      3'd2, 4'b1000, 24'h111111, 24'h222222}, // R4 pulse ends
    '{4'd11, 5'b00111, 24'h999999, 24'hAAAAAA, 3'd3, 4'b0010, 24'h333333, 24'h444444}, // R11 full both
    '{4'd11, 5'b00111, 24'h999999, 24'hAAAAAA, 3'd3, 4'b0000, 24'h555555, 24'h666666}, // R11 part both
    '{4'd5,  5'b00101, 24'h0,      24'h0,      3'd3, 4'b0000, 24'h777777, 24'h888888}, // R5 order
    '{4'd7,  5'b01111, 24'hBBBBBB, 24'hCCCCCC, 3'd5, 4'b0000, 24'h999999, 24'hAAAAAA}, // R7 stop to drain
    '{4'd7,  5'b00110, 24'hBBBBBB, 24'hCCCCCC, 3'd5, 4'b0000, 24'h999999, 24'hAAAAAA}, // R7 write ignored
    '{4'd7,  5'b00101, 24'h0,      24'h0,      3'd0, 4'b0100, 24'h0,      24'h0},      // R7 drained
    '{4'd2,  5'b10100, 24'h0,      24'h0,      3'd1, 4'b0100, 24'h0,      24'h0},      // R2 restart
    '{4'd2,  5'b00100, 24'h0,      24'h0,      3'd1, 4'b0100, 24'h0,      24'h0},      // R2
    '{4'd2,  5'b00100, 24'h0,      24'h0,      3'd1, 4'b0100, 24'h0,      24'h0},      // R2
    '{4'd2,  5'b00100, 24'h0,      24'h0,      3'd1, 4'b0100, 24'h0,      24'h0},      // R2
    '{4'd2,  5'b00100, 24'h0,      24'h0,      3'd4, 4'b0100, 24'h0,      24'h0},      // R2
    '{4'd9,  5'b00010, 24'hABCDEF, 24'h123456, 3'd3, 4'b0000, 24'h00CDEF, 24'h003456}, // R9 narrow
    '{4'd9,  5'b00110, 24'hFEDCBA, 24'h0F0F0F, 3'd3, 4'b0000, 24'h00CDEF, 24'h003456}, // R9 wide
    '{4'd5,  5'b00101, 24'h0,      24'h0,      3'd3, 4'b0000, 24'hFEDCBA, 24'h0F0F0F}, // R5
    '{4'd5,  5'b00101, 24'h0,      24'h0,      3'd4, 4'b0100, 24'h0,      24'h0},      // R5
    '{4'd8,  5'b01100, 24'h0,      24'h0,      3'd0, 4'b0100, 24'h0,      24'h0},      // R8 stop when empty
    '{4'd8,  5'b01100, 24'h0,      24'h0,      3'd0, 4'b0100, 24'h0,      24'h0}       // R8 stop in idle
  };

  task automatic chk(input int req, input string tag, input logic [2:0] st,
                     input logic [3:0] flg, input logic [23:0] hl, input logic [23:0] hr);
    logic [3:0] got;
    got = {full_o, empty_o, overflow_o, underrun_o};
    checks++;
    if (state_o !== st || got !== flg || head_left_o !== hl || head_right_o !== hr) begin
      errors++;
      $display("FAIL R%0d %s: state %0d flags %b head %h/%h, expected state %0d flags %b head %h/%h",
               req, tag, state_o, got, head_left_o, head_right_o, st, flg, hl, hr);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [23:0] l, input logic [23:0] r);
    {start_i, stop_i, wide_i, wr_i, rd_i} = c;
    wr_left_i  = l;
    wr_right_i = r;
    @(negedge clk);
  endtask

  task automatic open_buffer();
    drive(5'b10100, 24'h0, 24'h0);
    repeat (4) drive(5'b00100, 24'h0, 24'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(1, "reset held", 3'd0, 4'b0100, 24'h0, 24'h0);      // R1
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].ctl, TBL[i].l, TBL[i].r);
      chk(int'(TBL[i].req), $sformatf("vector %0d", i), TBL[i].st, TBL[i].flg, TBL[i].hl, TBL[i].hr);
    end

    // R1: reset in the middle of operation
    open_buffer();
    drive(5'b00110, 24'h0A0A0A, 24'h0B0B0B);
    chk(3, "before reset", 3'd3, 4'b0000, 24'h0A0A0A, 24'h0B0B0B);
    rst_n = 1'b0;
    drive(5'b00100, 24'h0, 24'h0);
    chk(1, "reset mid run", 3'd0, 4'b0100, 24'h0, 24'h0);
    rst_n = 1'b1;

    // R7: stop with a full buffer, drain all four in order
    open_buffer();
    drive(5'b00110, 24'h000001, 24'h100001);
    drive(5'b00110, 24'h000002, 24'h100002);
    drive(5'b00110, 24'h000003, 24'h100003);
    drive(5'b00110, 24'h000004, 24'h100004);
    chk(3, "filled", 3'd2, 4'b1000, 24'h000001, 24'h100001);
    drive(5'b01100, 24'h0, 24'h0);
    chk(7, "stop while full", 3'd5, 4'b1000, 24'h000001, 24'h100001);
    drive(5'b00110, 24'h0000FF, 24'h1000FF);
    chk(7, "write while draining", 3'd5, 4'b1000, 24'h000001, 24'h100001);
    drive(5'b00101, 24'h0, 24'h0);
    chk(5, "drain 1", 3'd5, 4'b0000, 24'h000002, 24'h100002);
    drive(5'b00101, 24'h0, 24'h0);
    chk(5, "drain 2", 3'd5, 4'b0000, 24'h000003, 24'h100003);
    drive(5'b00101, 24'h0, 24'h0);
    chk(5, "drain 3", 3'd5, 4'b0000, 24'h000004, 24'h100004);
    drive(5'b00101, 24'h0, 24'h0);
    chk(7, "drain last", 3'd0, 4'b0100, 24'h0, 24'h0);

    // R8: stop in the cycle that reads the only pair
    open_buffer();
    drive(5'b00110, 24'h00ABCD, 24'h00DCBA);
    drive(5'b01101, 24'h0, 24'h0);
    chk(8, "stop with last read", 3'd0, 4'b0100, 24'h0, 24'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL R1 watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule